// File: doc/BRIEF.md
# Register Error Recovery Sequencer

This block is the control sequencer that takes over when a protected register read turns out to hold a single-bit, correctable fault. The error-checking logic reports the fault along with the register tag, the corrected value and the reorder-buffer index of the oldest in-flight instruction that reads that register. The sequencer holds the pipeline and writes the repaired value back into the register file. It then asks the reorder buffer to discard everything from that oldest reader onward, and finally releases the pipeline so that fetch restarts at the first discarded instruction.

Recovery always takes four busy cycles, in this order: stall, write-back, flush, resume. Any error report that arrives while a recovery is in progress is dropped. The re-executed instructions read their registers again, so a fault that is still present is reported again. A double-bit fault cannot be repaired. It does not start a recovery; it sets a sticky fatal flag that only reset clears.

Top module: `reg_err_recovery_seq`

## Requirements
- R1: While reset is asserted and after it is released, stall_o, rf_we_o, flush_valid_o, resume_o and fatal_error_o are all 0.
- R2: A correctable report (err_valid_i=1, err_dbl_i=0) sampled while idle raises stall_o in the next cycle. stall_o then stays 1 for exactly four cycles, the last of which is the resume cycle.
- R3: In the second stalled cycle, rf_we_o is 1 for exactly one cycle. rf_waddr_o carries the tag and rf_wdata_o carries the corrected data captured with the accepted report.
- R4: In the third stalled cycle, flush_valid_o is 1 for exactly one cycle. flush_idx_o carries the 6-bit oldest-reader ROB index captured with the accepted report.
- R5: In the fourth stalled cycle, resume_o is 1 for one cycle. In the following cycle stall_o is 0.
- R6: Each accepted report produces exactly one write-back, then one flush, then one resume, in that order. No two of the three strobes are ever 1 in the same cycle.
- R7: Reports of either kind sampled while not idle are ignored. They do not change the write-back or flush values, do not lengthen the stall, add no strobes and do not set fatal_error_o.
- R8: A double-bit report (err_dbl_i=1) sampled while idle sets fatal_error_o from the next cycle until reset, with no stall and no strobes. If err_valid_i is also 1 in that cycle, the double-bit report wins.
- R9: A correctable report sampled in the idle cycle right after a resume cycle is accepted, so recoveries can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| err_valid_i | input | 1 | Error reported on a protected register read |
| err_dbl_i | input | 1 | Reported error is a double-bit, uncorrectable fault |
| err_tag_i | input | TAG_W | Register number of the faulty read |
| err_data_i | input | DATA_W | Corrected register value |
| oldest_idx_i | input | ROB_IDX_W | ROB index of the oldest in-flight reader of that register |
| stall_o | output | 1 | Hold the pipeline |
| rf_we_o | output | 1 | Register file write enable |
| rf_waddr_o | output | TAG_W | Register file write address |
| rf_wdata_o | output | DATA_W | Register file write data |
| flush_valid_o | output | 1 | Flush request strobe to the reorder buffer |
| flush_idx_o | output | ROB_IDX_W | First ROB index to flush |
| resume_o | output | 1 | Release pulse; fetch restarts at the flushed instruction |
| fatal_error_o | output | 1 | Sticky uncorrectable-error flag |

## Verification
Two pairs of events can land in the same cycle. The first pair is a new error report and the last busy cycle. The bench drives a report so that it is sampled during the resume cycle and checks that it is dropped. It also drives one in the idle cycle straight after resume and checks that a second recovery starts with no gap. The second pair is a correctable and a double-bit report raised together. The bench checks that only the fatal flag moves. A scoreboard receives the expected write-back, flush and resume items and compares them against the strobes as they appear. Any strobe that arrives with no queued item counts as a miscompare.

// File: rtl/rer_pkg.sv
package rer_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_STALL = 3'd1,
    ST_WB    = 3'd2,
    ST_FLUSH = 3'd3,
    ST_RES   = 3'd4
  } rer_state_e;
endpackage

// File: rtl/rer_fsm.sv
module rer_fsm
  import rer_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       err_valid_i,
  input  logic       err_dbl_i,
  output rer_state_e state_o,
  output logic       start_o,
  output logic       fatal_set_o
);
  rer_state_e state_q, state_d;
  logic idle;

  assign idle        = (state_q == ST_IDLE);
  // double-bit report wins over a correctable one in the same cycle
  assign fatal_set_o = idle & err_dbl_i;
  assign start_o     = idle & err_valid_i & ~err_dbl_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_o) state_d = ST_STALL;
      ST_STALL: state_d = ST_WB;
      ST_WB:    state_d = ST_FLUSH;
      ST_FLUSH: state_d = ST_RES;
      ST_RES:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/rer_capture.sv
module rer_capture #(
  parameter int unsigned TAG_W     = 5,
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned ROB_IDX_W = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic                 fatal_set_i,
  input  logic [TAG_W-1:0]     tag_i,
  input  logic [DATA_W-1:0]    data_i,
  input  logic [ROB_IDX_W-1:0] idx_i,
  output logic [TAG_W-1:0]     tag_o,
  output logic [DATA_W-1:0]    data_o,
  output logic [ROB_IDX_W-1:0] idx_o,
  output logic                 fatal_o
);
  logic [TAG_W-1:0]     tag_q;
  logic [DATA_W-1:0]    data_q;
  logic [ROB_IDX_W-1:0] idx_q;
  logic                 fatal_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q  <= '0;
      data_q <= '0;
      idx_q  <= '0;
    end else if (load_i) begin
      tag_q  <= tag_i;
      data_q <= data_i;
      idx_q  <= idx_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          fatal_q <= 1'b0;
    else if (fatal_set_i) fatal_q <= 1'b1;
  end

  assign tag_o   = tag_q;
  assign data_o  = data_q;
  assign idx_o   = idx_q;
  assign fatal_o = fatal_q;
endmodule

// File: rtl/rer_outdec.sv
module rer_outdec
  import rer_pkg::*;
(
  input  rer_state_e state_i,
  output logic       stall_o,
  output logic       we_o,
  output logic       flush_o,
  output logic       resume_o
);
  always_comb begin
    stall_o  = (state_i != ST_IDLE);
    we_o     = (state_i == ST_WB);
    flush_o  = (state_i == ST_FLUSH);
    resume_o = (state_i == ST_RES);
  end
endmodule

// File: rtl/reg_err_recovery_seq.sv
module reg_err_recovery_seq
  import rer_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 32,
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned ROB_DEPTH = 64,
  localparam int unsigned TAG_W     = $clog2(NUM_REGS),
  localparam int unsigned ROB_IDX_W = $clog2(ROB_DEPTH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 err_valid_i,
  input  logic                 err_dbl_i,
  input  logic [TAG_W-1:0]     err_tag_i,
  input  logic [DATA_W-1:0]    err_data_i,
  input  logic [ROB_IDX_W-1:0] oldest_idx_i,
  output logic                 stall_o,
  output logic                 rf_we_o,
  output logic [TAG_W-1:0]     rf_waddr_o,
  output logic [DATA_W-1:0]    rf_wdata_o,
  output logic                 flush_valid_o,
  output logic [ROB_IDX_W-1:0] flush_idx_o,
  output logic                 resume_o,
  output logic                 fatal_error_o
);
  rer_state_e state;
  logic       start, fatal_set;

  rer_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .err_valid_i (err_valid_i),
    .err_dbl_i   (err_dbl_i),
    .state_o     (state),
    .start_o     (start),
    .fatal_set_o (fatal_set)
  );

  rer_capture #(
    .TAG_W     (TAG_W),
    .DATA_W    (DATA_W),
    .ROB_IDX_W (ROB_IDX_W)
  ) u_cap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (start),
    .fatal_set_i (fatal_set),
    .tag_i       (err_tag_i),
    .data_i      (err_data_i),
    .idx_i       (oldest_idx_i),
    .tag_o       (rf_waddr_o),
    .data_o      (rf_wdata_o),
    .idx_o       (flush_idx_o),
    .fatal_o     (fatal_error_o)
  );

  rer_outdec u_dec (
    .state_i  (state),
    .stall_o  (stall_o),
    .we_o     (rf_we_o),
    .flush_o  (flush_valid_o),
    .resume_o (resume_o)
  );
endmodule

// File: rtl/reg_err_recovery_seq_chk.sv
module reg_err_recovery_seq_chk #(
  parameter int unsigned TAG_W     = 5,
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned ROB_IDX_W = 6
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 err_valid_i,
  input logic                 err_dbl_i,
  input logic                 stall_o,
  input logic                 rf_we_o,
  input logic [TAG_W-1:0]     rf_waddr_o,
  input logic [DATA_W-1:0]    rf_wdata_o,
  input logic                 flush_valid_o,
  input logic [ROB_IDX_W-1:0] flush_idx_o,
  input logic                 resume_o,
  input logic                 fatal_error_o
);
  a_r2_first_stall_no_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stall_o) |-> !rf_we_o);
  a_r3_we_inside_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> stall_o && $past(stall_o));
  a_r4_flush_after_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_valid_o |-> $past(rf_we_o));
  a_r4_idx_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && $past(stall_o)) |-> ($stable(flush_idx_o) && $stable(rf_wdata_o) && $stable(rf_waddr_o)));
  a_r5_resume_after_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |-> $past(flush_valid_o));
  a_r5_resume_ends_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |=> !stall_o);
  a_r6_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rf_we_o, flush_valid_o, resume_o}));
  a_r7_busy_no_fatal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && !resume_o && !fatal_error_o) |=> !fatal_error_o);
  a_r8_fatal_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_error_o |=> fatal_error_o);
  a_r8_dbl_no_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_o && err_dbl_i) |=> !stall_o);
  a_r9_accept_after_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_o && err_valid_i && !err_dbl_i) |=> stall_o);
endmodule

bind reg_err_recovery_seq reg_err_recovery_seq_chk #(
  .TAG_W     (TAG_W),
  .DATA_W    (DATA_W),
  .ROB_IDX_W (ROB_IDX_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .err_valid_i   (err_valid_i),
  .err_dbl_i     (err_dbl_i),
  .stall_o       (stall_o),
  .rf_we_o       (rf_we_o),
  .rf_waddr_o    (rf_waddr_o),
  .rf_wdata_o    (rf_wdata_o),
  .flush_valid_o (flush_valid_o),
  .flush_idx_o   (flush_idx_o),
  .resume_o      (resume_o),
  .fatal_error_o (fatal_error_o)
);

// File: tb/reg_err_recovery_seq_tb_top.sv
`timescale 1ns/1ps
module reg_err_recovery_seq_tb_top;
  localparam int TW = 5;
  localparam int DW = 64;
  localparam int IW = 6;
  localparam int K_WB = 0, K_FL = 1, K_RS = 2;

  typedef struct {
    int          kind;
    logic [TW-1:0] tag;
    logic [DW-1:0] data;
    logic [IW-1:0] idx;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic err_valid = 1'b0, err_dbl = 1'b0;
  logic [TW-1:0] err_tag = '0;
  logic [DW-1:0] err_data = '0;
  logic [IW-1:0] old_idx = '0;
  logic stall, we, flv, res, fatal;
  logic [TW-1:0] waddr;
  logic [DW-1:0] wdata;
  logic [IW-1:0] fidx;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  reg_err_recovery_seq dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .err_valid_i(err_valid), .err_dbl_i(err_dbl),
    .err_tag_i(err_tag), .err_data_i(err_data), .oldest_idx_i(old_idx),
    .stall_o(stall), .rf_we_o(we), .rf_waddr_o(waddr), .rf_wdata_o(wdata),
    .flush_valid_o(flv), .flush_idx_o(fidx), .resume_o(res),
    .fatal_error_o(fatal)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: compare strobes against scoreboard (R3 R4 R5 R6)
  always @(negedge clk) begin
    if (rst_ni && (we || flv || res)) begin
      int k;
      exp_t e;
      k = we ? K_WB : (flv ? K_FL : K_RS);
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R6: unexpected strobe kind %0d expected none", k);
      end else begin
        e = exp_q.pop_front();
        chk("R6 order", k, e.kind);
        if (k == K_WB) begin
          chk("R3 waddr", waddr, e.tag);
          chk("R3 wdata", wdata, e.data);
        end else if (k == K_FL) begin
          chk("R4 flush idx", fidx, e.idx);
        end
      end
    end
  end

  // driver: called at a negedge with the design idle; returns at a negedge, idle
  // mode 1: inject ignored reports during the busy window (R7)
  task automatic recover(input logic [TW-1:0] t, input logic [DW-1:0] d,
                         input logic [IW-1:0] ix, input int mode);
    exp_q.push_back('{K_WB, t, d, '0});
    exp_q.push_back('{K_FL, '0, '0, ix});
    exp_q.push_back('{K_RS, '0, '0, '0});
    err_valid = 1'b1; err_dbl = 1'b0; err_tag = t; err_data = d; old_idx = ix;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      err_valid = 1'b0; err_dbl = 1'b0;
      if (mode == 1 && k == 1) begin
        err_valid = 1'b1; err_tag = ~t; err_data = ~d; old_idx = ~ix;
      end
      if (mode == 1 && k == 2) err_dbl = 1'b1;
      if (mode == 1 && k == 4) begin
        err_valid = 1'b1; err_tag = t ^ 1; err_data = d ^ 1; old_idx = ix ^ 1;
      end
      chk(k <= 4 ? "R2 stall held" : "R5 stall drops", stall, k <= 4);
      chk("R3 we cycle", we, k == 2);
      chk("R4 flush cycle", flv, k == 3);
      chk("R5 resume cycle", res, k == 4);
    end
    err_valid = 1'b0; err_dbl = 1'b0;
    if (mode == 1) begin
      chk("R7 no fatal from busy dbl", fatal, 1'b0);
      chk("R7 no extra items", exp_q.size(), 0);
    end
  endtask

  initial begin
    #1;
    chk("R1 reset stall", stall, 1'b0);
    chk("R1 reset fatal", fatal, 1'b0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 post-reset strobes", {we, flv, res}, 3'b000);
    chk("R1 post-reset stall", stall, 1'b0);

    recover(5'd3, 64'hDEAD_BEEF_0123_4567, 6'd17, 0);
    recover(5'd31, 64'hFFFF_0000_FFFF_0000, 6'd63, 1);
    // R9 back-to-back: previous call returned in the idle cycle after resume
    recover(5'd0, 64'h0, 6'd0, 0);
    recover(5'd12, 64'h1234_5678_9ABC_DEF0, 6'd42, 0);
    repeat (3) @(negedge clk);
    chk("R6 no stray strobes", exp_q.size(), 0);

    // R8: double-bit together with correctable, double wins
    err_valid = 1'b1; err_dbl = 1'b1; err_tag = 5'd7; old_idx = 6'd9;
    @(negedge clk);
    err_valid = 1'b0; err_dbl = 1'b0;
    chk("R8 fatal set", fatal, 1'b1);
    chk("R8 no stall", stall, 1'b0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R8 fatal sticky", fatal, 1'b1);
      chk("R8 no stall later", stall, 1'b0);
    end
    recover(5'd9, 64'hA5A5_A5A5_5A5A_5A5A, 6'd33, 0);
    chk("R8 fatal kept", fatal, 1'b1);

    rst_ni = 1'b0;
    @(negedge clk);
    chk("R8 fatal cleared by reset", fatal, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule